// File: doc/BRIEF.md
# Synchronous Serial Master with Single and Continuous Transfer Modes

This block is a clocked serial master that moves fixed-width frames out on a data-out pin and captures frames from a data-in pin, with a serial clock it generates itself. Software or a DMA engine writes a transmit byte and reads back a receive byte. A status flag shows that a transfer is pending or running. Two configuration bits pick the serial clock idle level and the edge on which data is captured, which gives four communication types.

Two transfer modes exist. In single mode each write starts exactly one frame, and writes that arrive while the status flag is set are dropped. In continuous mode a one-entry transmit buffer sits in front of the shifter. A buffer refilled before the current frame ends chains into the next frame with no idle gap. The two interrupt pulses follow mode-specific rules: in continuous mode the transmit pulse marks the buffer emptying into the shifter, while in single mode only the end-of-transfer pulse is raised.

Top module: `sync_serial_master`

## Requirements
- R1: A frame is 8 bits. The transmit byte leaves on `so_o` most significant bit first. Bits captured from `si_i` are assembled so that the first captured bit becomes bit 7 of `rx_data_o`.
- R2: While no transfer runs, `sck_o` equals `cpol_i`. During a frame each half period of `sck_o` lasts `div_i`+1 system clocks, and a frame holds 16 clock edges, after which `sck_o` is back at `cpol_i`.
- R3: With `cpha_i`=0, the first bit is on `so_o` from the cycle the frame starts, `si_i` is captured on each odd-numbered `sck_o` edge (1st, 3rd, ...), and `so_o` changes on the even-numbered edges. With `cpha_i`=1, `so_o` changes on the odd-numbered edges and `si_i` is captured on the even-numbered ones.
- R4: In single mode (`cont_i`=0), `tx_irq_o` is never raised.
- R5: In single mode, `rx_irq_o` pulses for one cycle after every frame, even with `rx_en_i`=0. `rx_data_o` is updated only when `rx_en_i`=1.
- R6: In single mode, a write while `tsf_o`=1 is ignored and does not change the frame in progress.
- R7: In continuous mode (`cont_i`=1), `tx_irq_o` pulses for one cycle, in the first cycle of each frame, when the buffered byte has moved into the shifter.
- R8: In continuous mode, `rx_irq_o` pulses after a frame only when `rx_en_i`=1, in the same cycle that `rx_data_o` first shows that frame's data.
- R9: In continuous mode, a frame whose buffer was refilled before its last edge is followed directly by the next frame, with `tsf_o` held at 1. Otherwise `sck_o` returns to idle.
- R10: `tsf_o` rises in the cycle after an accepted write and falls in the cycle after the last edge of the final frame.
- R11: In continuous mode, a write while the transmit buffer is occupied is ignored.
- R12: After reset, `tsf_o`, `tx_irq_o`, `rx_irq_o` and `rx_data_o` are 0 and `sck_o` equals `cpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cont_i | input | 1 | 1 = continuous mode, 0 = single mode |
| rx_en_i | input | 1 | Receive enable |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Capture-edge select |
| div_i | input | DIV_W | Half period of serial clock minus one, in system clocks |
| tx_wr_i | input | 1 | Transmit register write strobe |
| tx_data_i | input | DATA_W | Transmit byte |
| rx_data_o | output | DATA_W | Last received byte |
| tsf_o | output | 1 | Transfer status flag |
| sck_o | output | 1 | Serial clock |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=3. It sweeps the divider through 0, 1 and 3. The value 0 gives the fastest serial clock, where every system clock is a serial edge and a frame end and the next start fall in the same cycle. The wider settings separate edges by idle cycles, so a capture or shift on the wrong cycle shows up. All four communication types run under each mode, and the data-in line changes every cycle, so capturing on the wrong edge yields a different received byte.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef struct packed {
    logic cont;
    logic rx_en;
    logic cpol;
    logic cpha;
  } ssm_cfg_t;
endpackage

// File: rtl/ssm_tick_gen.sv
module ssm_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/ssm_shift_engine.sv
module ssm_shift_engine
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ssm_cfg_t          cfg_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              tick_i,
  input  logic              si_i,
  output logic              sck_o,
  output logic              so_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]     edge_q;
  logic              sck_q, so_q;
  logic [DATA_W-1:0] tx_q, rx_q, tx_sh;
  logic [EW-1:0]     ord;
  logic              lead, sample_now, shift_now;

  assign lead       = ~edge_q[0];
  assign last_o     = tick_i && (edge_q == EW'(EDGES - 1));
  assign sample_now = tick_i && (lead ^ cfg_i.cpha);
  assign shift_now  = tick_i && !(lead ^ cfg_i.cpha) && (edge_q != EW'(EDGES - 1));
  // bit number leaving on this shift edge
  assign ord        = (edge_q + EW'(!cfg_i.cpha)) >> 1;
  assign tx_sh      = tx_q << ord;
  assign rx_word_o  = sample_now ? {rx_q[DATA_W-2:0], si_i} : rx_q;
  assign sck_o      = sck_q;
  assign so_o       = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      sck_q  <= 1'b0;
      so_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      edge_q <= '0;
      sck_q  <= cfg_i.cpol;
      tx_q   <= load_i;
      rx_q   <= '0;
      if (!cfg_i.cpha) so_q <= load_i[DATA_W-1];
    end else if (tick_i) begin
      edge_q <= edge_q + 1'b1;
      sck_q  <= ~sck_q;
      if (sample_now) rx_q <= rx_word_o;
      if (shift_now)  so_q <= tx_sh[DATA_W-1];
    end
  end

  assert_last_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (sck_q != cfg_i.cpol));
  assert_so_edges_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i || start_i) |=> $stable(so_o));
endmodule

// File: rtl/ssm_xfer_ctrl.sv
module ssm_xfer_ctrl
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ssm_cfg_t          cfg_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              start_o,
  output logic [DATA_W-1:0] load_o,
  output logic              busy_o,
  output logic              tsf_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic              buf_full_q, busy_q, tx_irq_q, rx_irq_q;
  logic [DATA_W-1:0] buf_q, rx_data_q;
  logic              accept;

  assign accept    = tx_wr_i && (cfg_i.cont ? !buf_full_q : !(busy_q || buf_full_q));
  assign start_o   = buf_full_q && (!busy_q || last_i);
  assign load_o    = buf_q;
  assign busy_o    = busy_q;
  assign tsf_o     = busy_q || buf_full_q;
  assign tx_irq_o  = tx_irq_q;
  assign rx_irq_o  = rx_irq_q;
  assign rx_data_o = rx_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
      busy_q     <= 1'b0;
      tx_irq_q   <= 1'b0;
      rx_irq_q   <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      if (start_o)     buf_full_q <= 1'b0;
      else if (accept) buf_full_q <= 1'b1;
      if (accept) buf_q <= tx_data_i;
      if (start_o)     busy_q <= 1'b1;
      else if (last_i) busy_q <= 1'b0;
      tx_irq_q <= start_o && cfg_i.cont;
      rx_irq_q <= last_i && (!cfg_i.cont || cfg_i.rx_en);
      if (last_i && cfg_i.rx_en) rx_data_q <= rx_word_i;
    end
  end

  assert_single_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.cont && tx_wr_i && busy_q && !last_i) |=> !buf_full_q);
  assert_no_txirq_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $past(cfg_i.cont));
  assert_txirq_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> busy_q);
  assert_rxirq_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(last_i));
  assert_chain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && buf_full_q) |=> busy_q);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_i,
  input  logic              rx_en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tsf_o,
  output logic              sck_o,
  output logic              so_o,
  input  logic              si_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  ssm_cfg_t          cfg;
  logic              tick, start, last, busy, sck_int;
  logic [DATA_W-1:0] load, rx_word;

  assign cfg   = '{cont: cont_i, rx_en: rx_en_i, cpol: cpol_i, cpha: cpha_i};
  assign sck_o = busy ? sck_int : cpol_i;

  ssm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(busy), .div_i, .tick_o(tick)
  );

  ssm_shift_engine #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_i(start), .load_i(load),
    .tick_i(tick), .si_i, .sck_o(sck_int), .so_o, .last_o(last),
    .rx_word_o(rx_word)
  );

  ssm_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .cfg_i(cfg), .tx_wr_i, .tx_data_i, .last_i(last),
    .rx_word_i(rx_word), .start_o(start), .load_o(load), .busy_o(busy),
    .tsf_o, .tx_irq_o, .rx_irq_o, .rx_data_o
  );

  assert_idle_sck_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tsf_o |-> (sck_o == cpol_i));
endmodule

// File: tb/tb_sync_serial_master.sv
module tb_sync_serial_master;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 3;

  logic clk = 0, rst_n = 0;
  logic cont = 0, rx_en = 0, cpol = 0, cpha = 0, tx_wr = 0, si = 0;
  logic [DIV_W-1:0]  div = 0;
  logic [DATA_W-1:0] tx_data = 0;
  logic [DATA_W-1:0] rx_data;
  logic tsf, sck, so, tx_irq, rx_irq;

  int checks = 0, errs = 0, cyc = 0;
  int cnt_tx = 0, cnt_rx = 0, tsf_falls = 0;
  bit run_chk = 0, tsf_d = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  bit m_busy, m_pend, m_sck, m_so, m_txirq, m_rxirq;
  int m_buf, m_txb, m_cnt, m_edge, m_rx, m_rxd;

  sync_serial_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cont_i(cont), .rx_en_i(rx_en), .cpol_i(cpol),
    .cpha_i(cpha), .div_i(div), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .rx_data_o(rx_data), .tsf_o(tsf), .sck_o(sck), .so_o(so), .si_i(si),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    si   <= lfsr[0];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_sck = 0; m_so = 0; m_txirq = 0; m_rxirq = 0;
      m_buf = 0; m_txb = 0; m_cnt = 0; m_edge = 0; m_rx = 0; m_rxd = 0;
    end else begin
      bit fin, ok, st, lead, samp;
      int bn;
      fin = 0;
      ok  = tx_wr && (cont ? !m_pend : !(m_busy || m_pend));
      m_txirq = 0; m_rxirq = 0;
      if (m_busy) begin
        if (m_cnt == int'(div)) begin
          m_cnt = 0;
          lead = (m_edge % 2) == 0;
          samp = cpha ? !lead : lead;
          if (samp) m_rx = ((m_rx << 1) | int'(si)) & 255;
          else if (!(cpha == 0 && m_edge == 15)) begin
            bn = cpha ? m_edge / 2 : (m_edge + 1) / 2;
            m_so = m_txb[7 - bn];
          end
          m_sck = !m_sck;
          if (m_edge == 15) fin = 1;
          m_edge++;
        end else m_cnt++;
      end
      st = m_pend && (!m_busy || fin);
      if (fin) begin
        if (!cont || rx_en) m_rxirq = 1;
        if (rx_en) m_rxd = m_rx;
        if (!st) m_busy = 0;
      end
      if (st) begin
        m_busy = 1; m_pend = 0; m_txb = m_buf; m_edge = 0; m_cnt = 0;
        m_sck = cpol; m_rx = 0;
        if (!cpha) m_so = m_txb[7];
        m_txirq = cont;
      end
      if (ok) begin m_pend = 1; m_buf = int'(tx_data); end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check(sck === (m_busy ? m_sck : cpol), "R2 sck", int'(sck), int'(m_busy ? m_sck : cpol));
      if (m_busy) check(so === m_so, "R1/R3 so", int'(so), int'(m_so));
      check(tsf === (m_busy || m_pend), "R10 tsf", int'(tsf), int'(m_busy || m_pend));
      check(tx_irq === m_txirq, cont ? "R7 tx_irq" : "R4 tx_irq", int'(tx_irq), int'(m_txirq));
      check(rx_irq === m_rxirq, cont ? "R8 rx_irq" : "R5 rx_irq", int'(rx_irq), int'(m_rxirq));
      check(int'(rx_data) == m_rxd, "R1 rx_data", int'(rx_data), m_rxd);
      if (tx_irq) cnt_tx++;
      if (rx_irq) cnt_rx++;
      if (tsf_d && !tsf) tsf_falls++;
      tsf_d = tsf;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errs++;
      $display("FAIL watchdog expired: actual %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
    end
  end

  task automatic setcfg(input bit c, input bit re, input bit pl, input bit ph, input int d);
    @(negedge clk); #1;
    cont = c; rx_en = re; cpol = pl; cpha = ph; div = DIV_W'(d);
  endtask

  task automatic write(input int b);
    @(negedge clk); #1;
    tx_wr = 1; tx_data = DATA_W'(b);
    @(negedge clk); #1;
    tx_wr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tsf) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_txirq();
    @(negedge clk);
    while (!tx_irq) @(negedge clk);
  endtask

  initial begin
    int t0, r0, f0, d0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(tsf === 0, "R12 tsf", int'(tsf), 0);
    check(tx_irq === 0 && rx_irq === 0, "R12 irq", int'(tx_irq | rx_irq), 0);
    check(rx_data === 0, "R12 rx_data", int'(rx_data), 0);
    check(sck === cpol, "R12 sck", int'(sck), int'(cpol));
    #1 rst_n = 1;
    run_chk = 1;

    // single mode, all four communication types, several dividers
    for (int d = 0; d < 3; d++) begin
      for (int ty = 0; ty < 4; ty++) begin
        setcfg(0, 1, ty[1], ty[0], (d == 2) ? 3 : d);
        t0 = cnt_tx; r0 = cnt_rx;
        write(8'hA5 ^ (ty * 37 + d * 11));
        wait_idle();
        check(cnt_tx == t0, "R4 no tx_irq in single", cnt_tx - t0, 0);
        check(cnt_rx == r0 + 1, "R5 one rx_irq per frame", cnt_rx - r0, 1);
        check(sck === cpol, "R3 sck idle after frame", int'(sck), int'(cpol));
      end
    end

    // R5: receive disabled in single mode
    setcfg(0, 0, 1, 0, 1);
    d0 = int'(rx_data); r0 = cnt_rx;
    write(8'h3C);
    wait_idle();
    check(cnt_rx == r0 + 1, "R5 rx_irq with rx disabled", cnt_rx - r0, 1);
    check(int'(rx_data) == d0, "R5 rx_data held", int'(rx_data), d0);

    // R6: write during busy in single mode dropped
    setcfg(0, 1, 0, 1, 2);
    r0 = cnt_rx;
    write(8'hC3);
    repeat (4) @(negedge clk);
    write(8'h18);
    wait_idle();
    repeat (8) @(negedge clk);
    check(cnt_rx == r0 + 1, "R6 dropped write starts no frame", cnt_rx - r0, 1);
    check(tsf === 0, "R6 flag clear", int'(tsf), 0);

    // R7/R8/R9/R11: continuous back-to-back, third write dropped
    for (int ty = 0; ty < 4; ty++) begin
      setcfg(1, 1, ty[1], ty[0], ty % 2);
      t0 = cnt_tx; r0 = cnt_rx; f0 = tsf_falls;
      write(8'h96 + ty);
      wait_txirq();
      write(8'h5A - ty);
      write(8'hFF);
      wait_idle();
      repeat (8) @(negedge clk);
      check(cnt_tx == t0 + 2, "R7 tx_irq per buffer load", cnt_tx - t0, 2);
      check(cnt_rx == r0 + 2, "R8 rx_irq per frame", cnt_rx - r0, 2);
      check(tsf_falls == f0 + 1, "R9 no gap between frames", tsf_falls - f0, 1);
      check(cnt_tx != t0 + 3, "R11 write to full buffer dropped", cnt_tx - t0, 2);
    end

    // R8: continuous without receive
    setcfg(1, 0, 0, 0, 0);
    r0 = cnt_rx; t0 = cnt_tx; d0 = int'(rx_data);
    write(8'h81);
    wait_idle();
    check(cnt_rx == r0, "R8 no rx_irq with rx disabled", cnt_rx - r0, 0);
    check(cnt_tx == t0 + 1, "R7 tx_irq single frame", cnt_tx - t0, 1);
    check(int'(rx_data) == d0, "R8 rx_data held", int'(rx_data), d0);

    // R9: refill after frame end leaves an idle gap
    setcfg(1, 1, 1, 1, 1);
    f0 = tsf_falls;
    write(8'h42);
    wait_idle();
    check(sck === 1'b1, "R9 sck idle in gap", int'(sck), 1);
    write(8'h24);
    wait_idle();
    check(tsf_falls == f0 + 2, "R9 two separate bursts", tsf_falls - f0, 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end
endmodule